// File: doc/BRIEF.md
# UART Receive Timeout Interrupt Controller

This block raises the receive-timeout interrupt of a FIFO-based UART receiver. It watches whether the receive FIFO holds data and counts one-cycle character-time ticks toward a programmable 16-bit threshold. Software loads the threshold one byte at a time. When the count reaches the threshold, the block latches a pending interrupt. It also emits a one-cycle DMA receive request when DMA operation is enabled. Software reads the interrupt-identification port to see a timeout code, and that read clears the pending interrupt.

Two behaviours are selectable through bit 6 of a mode-register write. In normal mode the counter runs only while the FIFO is non-empty. It starts again whenever a character arrives or the holding register is read. If data is still waiting after a clear, the timeout elapses again and the interrupt returns. In periodic mode the counter fires on every expiry, whatever the FIFO holds. A DMA-driven receiver therefore always gets another event after a clear. Reads of the holding, modem-status and line-status registers never set or clear the interrupt.

Top module: `rto_ctrl`

## Requirements
- R1: The threshold is 16 bits. A write strobe for the upper byte loads bits 15:8 from the write data, and a write strobe for the lower byte loads bits 7:0. The threshold is zero after reset.
- R2: A mode-register write takes bit 6 of the write data as the mode: 0 selects normal mode, 1 selects periodic mode. After reset the mode is normal.
- R3: In normal mode, with the FIFO non-empty and no restart, the interrupt output goes high on the clock edge that takes the threshold-th tick. It is low before that edge.
- R4: In normal mode the count restarts from zero on a received-character strobe, on a holding-register read, and in any cycle where the FIFO is empty.
- R5: In periodic mode an expiry happens every threshold ticks, whatever the FIFO state and whether characters arrive.
- R6: A read of the identification port clears the pending interrupt at that clock edge. If an expiry happens in the same cycle, the interrupt stays set.
- R7: After a clear in normal mode with data still in the FIFO, the interrupt asserts again after another threshold ticks.
- R8: Holding-register, modem-status and line-status reads never set or clear the interrupt.
- R9: The identification code is 4'hC while the timeout is pending and 4'h1 otherwise.
- R10: A threshold of zero stops all expiries: no interrupt and no DMA request.
- R11: Any write to a threshold byte or to the mode register restarts the count from zero.
- R12: While the DMA enable is high, each expiry gives a one-cycle DMA receive request on the following cycle. While it is low, no request is made.
- R13: After reset the interrupt is low, the identification code is 4'h1, and the DMA request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoNonEmpty | input | 1 | Receive FIFO holds at least one character |
| charRecv | input | 1 | One-cycle strobe: a character was pushed into the FIFO |
| charTick | input | 1 | One-cycle character-time tick |
| dmaEnable | input | 1 | DMA receive operation enabled |
| wrData | input | 8 | Register write data |
| wrLimitHi | input | 1 | Write strobe, threshold upper byte |
| wrLimitLo | input | 1 | Write strobe, threshold lower byte |
| wrMode | input | 1 | Write strobe, mode register (bit 6 = periodic) |
| rdHolding | input | 1 | Read strobe, receive holding register |
| rdModemStat | input | 1 | Read strobe, modem status register |
| rdLineStat | input | 1 | Read strobe, line status register |
| rdIdent | input | 1 | Read strobe, interrupt identification register |
| irqOut | output | 1 | Receive-timeout interrupt pending |
| identCode | output | 4 | Interrupt identification code |
| dmaRxReq | output | 1 | One-cycle DMA receive request |

## Verification
Some properties are checked on every cycle:
- a status read cannot drop a pending interrupt;
- an identification read clears it unless an expiry happens in the same cycle;
- an interrupt only rises after a tick;
- a zero threshold never expires;
- the DMA request is gated by its enable and never appears without the interrupt;
- the identification code always follows the interrupt.

Other behaviours need the bench's scenarios: the exact tick count to an expiry, the restarts from characters, holding reads, an empty FIFO and configuration writes, the re-arm after a clear, periodic recurrence with an empty FIFO, and the use of the upper threshold byte.

// File: rtl/rto_pkg.sv
package rto_pkg;
  localparam logic [3:0] ID_TIMEOUT = 4'hC;
  localparam logic [3:0] ID_NONE    = 4'h1;

  typedef struct packed {
    logic restart;
    logic advance;
  } ctrlStrobes_t;
endpackage

// File: rtl/rto_datapath.sv
module rto_datapath
  import rto_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int MODE_BIT = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic                wrLimitHi,
  input  logic                wrLimitLo,
  input  logic                wrMode,
  output logic [2*BYTE_W-1:0] limitVal,
  output logic                periodicMode,
  output logic                expireEvt
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countNext;

  // Threshold byte lanes: lane 0 is the low byte, lane 1 the high byte.
  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic laneWr;
    assign laneWr = (lane == 0) ? wrLimitLo : wrLimitHi;
    always_ff @(posedge clk) begin
      if (!rstN) limitVal[lane*BYTE_W +: BYTE_W] <= '0;
      else if (laneWr) limitVal[lane*BYTE_W +: BYTE_W] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) periodicMode <= 1'b0;
    else if (wrMode) periodicMode <= wrData[MODE_BIT];
  end

  assign countNext = count + 1'b1;
  assign expireEvt = strobes.advance && !strobes.restart && (countNext == limitVal);

  always_ff @(posedge clk) begin
    if (!rstN)                 count <= '0;
    else if (strobes.restart)  count <= '0;
    else if (expireEvt)        count <= '0;
    else if (strobes.advance)  count <= countNext;
  end
endmodule

// File: rtl/rto_control.sv
module rto_control
  import rto_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fifoNonEmpty,
  input  logic         charRecv,
  input  logic         charTick,
  input  logic         dmaEnable,
  input  logic         cfgWrite,
  input  logic         rdHolding,
  input  logic         rdIdent,
  input  logic         periodicMode,
  input  logic         limitZero,
  input  logic         expireEvt,
  output ctrlStrobes_t strobes,
  output logic         pending,
  output logic         dmaReq,
  output logic [3:0]   identCode
);
  logic normalRestart;

  // Only the holding read touches the count; status reads are not inputs here.
  assign normalRestart = !periodicMode && (charRecv || rdHolding || !fifoNonEmpty);

  always_comb begin
    strobes.restart = cfgWrite || normalRestart;
    strobes.advance = charTick && !limitZero && (periodicMode || fifoNonEmpty);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      dmaReq  <= 1'b0;
    end else begin
      if (expireEvt)    pending <= 1'b1;
      else if (rdIdent) pending <= 1'b0;
      dmaReq <= expireEvt && dmaEnable;
    end
  end

  assign identCode = pending ? ID_TIMEOUT : ID_NONE;
endmodule

// File: rtl/rto_ctrl.sv
module rto_ctrl
  import rto_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int MODE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoNonEmpty,
  input  logic              charRecv,
  input  logic              charTick,
  input  logic              dmaEnable,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrLimitHi,
  input  logic              wrLimitLo,
  input  logic              wrMode,
  input  logic              rdHolding,
  input  logic              rdModemStat,
  input  logic              rdLineStat,
  input  logic              rdIdent,
  output logic              irqOut,
  output logic [3:0]        identCode,
  output logic              dmaRxReq
);
  ctrlStrobes_t          strobes;
  logic [2*BYTE_W-1:0]   limitVal;
  logic                  periodicMode;
  logic                  expireEvt;
  logic                  statusReadSeen;

  // Status reads are decoded here only so that they are visibly unused.
  assign statusReadSeen = rdModemStat | rdLineStat;

  rto_datapath #(.BYTE_W(BYTE_W), .MODE_BIT(MODE_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .wrLimitHi(wrLimitHi), .wrLimitLo(wrLimitLo), .wrMode(wrMode),
    .limitVal(limitVal), .periodicMode(periodicMode), .expireEvt(expireEvt)
  );

  rto_control u_ctl (
    .clk(clk), .rstN(rstN), .fifoNonEmpty(fifoNonEmpty), .charRecv(charRecv),
    .charTick(charTick), .dmaEnable(dmaEnable),
    .cfgWrite(wrLimitHi | wrLimitLo | wrMode),
    .rdHolding(rdHolding), .rdIdent(rdIdent), .periodicMode(periodicMode),
    .limitZero(limitVal == '0), .expireEvt(expireEvt), .strobes(strobes),
    .pending(irqOut), .dmaReq(dmaRxReq), .identCode(identCode)
  );

  logic unusedOk;
  assign unusedOk = &{1'b0, statusReadSeen};
endmodule

// File: rtl/rto_checker.sv
module rto_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             charTick,
  input logic             dmaEnable,
  input logic             rdIdent,
  input logic             irqOut,
  input logic [3:0]       identCode,
  input logic             dmaRxReq,
  input logic             expireEvt,
  input logic [CNT_W-1:0] limitVal
);
  // R8: an interrupt only appears after a tick, never after a status read alone
  assert_rise_needs_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(charTick));

  // R8: only the identification read may drop the interrupt
  assert_status_read_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !rdIdent) |=> irqOut);

  // R6: identification read clears unless an expiry coincides
  assert_ident_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdent && !expireEvt) |=> !irqOut);

  // R10: zero threshold never expires
  assert_zero_limit_silent_R10: assert property (@(posedge clk) disable iff (!rstN)
    (limitVal == '0) |-> !expireEvt);

  // R12: no DMA request while disabled
  assert_dma_gated_R12: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEnable |=> !dmaRxReq);

  // R12: a DMA request always comes with the interrupt
  assert_dma_with_irq_R12: assert property (@(posedge clk) disable iff (!rstN)
    dmaRxReq |-> irqOut);

  // R9: identification code follows the pending state
  assert_ident_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    identCode == (irqOut ? 4'hC : 4'h1));
endmodule

bind rto_ctrl rto_checker #(.CNT_W(2*BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .charTick(charTick), .dmaEnable(dmaEnable),
  .rdIdent(rdIdent), .irqOut(irqOut), .identCode(identCode), .dmaRxReq(dmaRxReq),
  .expireEvt(expireEvt), .limitVal(limitVal)
);

// File: tb/tb_rto_ctrl.sv
module tb_rto_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fifoNonEmpty = 0, charRecv = 0, charTick = 0, dmaEnable = 0;
  logic [7:0] wrData = 0;
  logic wrLimitHi = 0, wrLimitLo = 0, wrMode = 0;
  logic rdHolding = 0, rdModemStat = 0, rdLineStat = 0, rdIdent = 0;
  logic irqOut, dmaRxReq;
  logic [3:0] identCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rto_ctrl dut (.*);

  // Reference model built from the requirements, stepped on each edge
  logic [15:0] mLim = 0;
  logic [16:0] mCnt = 0;
  logic mPer = 0, mPend = 0, mDma = 0;

  function automatic logic [3:0] expIdent(input logic p);
    return p ? 4'hC : 4'h1;
  endfunction

  function automatic logic restartOf(input logic per, input logic cfg, input logic cr,
                                     input logic rh, input logic ne);
    return cfg || (!per && (cr || rh || !ne));
  endfunction

  always @(posedge clk) begin
    logic rs, adv, ex;
    if (!rstN) begin
      mLim = 0; mCnt = 0; mPer = 0; mPend = 0; mDma = 0;
    end else begin
      rs  = restartOf(mPer, wrLimitHi | wrLimitLo | wrMode, charRecv, rdHolding, fifoNonEmpty);
      adv = charTick && (mLim != 0) && (mPer || fifoNonEmpty);
      ex  = 0;
      if (rs) mCnt = 0;
      else if (adv) begin
        if (mCnt + 1 == {1'b0, mLim}) begin ex = 1; mCnt = 0; end
        else mCnt = mCnt + 1;
      end
      if (ex) mPend = 1; else if (rdIdent) mPend = 0;
      mDma = ex && dmaEnable;
      if (wrLimitHi) mLim[15:8] = wrData;
      if (wrLimitLo) mLim[7:0]  = wrData;
      if (wrMode)    mPer       = wrData[6];
    end
  end

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    charRecv = 0; charTick = 0; wrLimitHi = 0; wrLimitLo = 0; wrMode = 0;
    rdHolding = 0; rdModemStat = 0; rdLineStat = 0; rdIdent = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin charTick = 1; step(); end
  endtask

  task automatic writeLimit(input logic [15:0] v);
    wrData = v[15:8]; wrLimitHi = 1; step();
    wrData = v[7:0];  wrLimitLo = 1; step();
  endtask

  task automatic writeMode(input logic per);
    wrData = per ? 8'h40 : 8'h00; wrMode = 1; step();
  endtask

  task automatic clearIrq();
    rdIdent = 1; step();
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    step();
    // R13 reset state
    check(irqOut, 0, "R13 irq");
    check(identCode, 4'h1, "R13 ident");
    check(dmaRxReq, 0, "R13 dma");

    // R1 R3 basic normal-mode expiry with limit 3
    fifoNonEmpty = 1; dmaEnable = 1;
    writeLimit(16'd3); writeMode(0);
    ticks(2);
    check(irqOut, 0, "R3 before threshold");
    ticks(1);
    check(irqOut, 1, "R3 at threshold");
    check(dmaRxReq, 1, "R12 dma pulse");
    check(identCode, 4'hC, "R9 timeout code");
    step();
    check(dmaRxReq, 0, "R12 dma one cycle");

    // R8 status and holding reads leave the interrupt
    rdLineStat = 1; rdModemStat = 1; step();
    rdHolding = 1; step();
    check(irqOut, 1, "R8 reads keep irq");

    // R6 identification read clears
    clearIrq();
    check(irqOut, 0, "R6 cleared");
    check(identCode, 4'h1, "R9 none code");

    // R7 refire with data still pending
    ticks(2);
    check(irqOut, 0, "R7 not yet");
    ticks(1);
    check(irqOut, 1, "R7 refired");
    clearIrq();

    // R4 character restarts count
    ticks(2); charRecv = 1; step(); ticks(2);
    check(irqOut, 0, "R4 char restart");
    ticks(1);
    check(irqOut, 1, "R4 fires after restart");
    clearIrq();

    // R4 holding read restarts, status reads never set
    ticks(2); rdHolding = 1; rdLineStat = 1; step(); ticks(2);
    check(irqOut, 0, "R4 holding restart");
    ticks(1); clearIrq();

    // R4 empty FIFO in normal mode: nothing
    fifoNonEmpty = 0; dmaEnable = 0;
    ticks(5);
    check(irqOut, 0, "R4 empty fifo");

    // R2 R5 periodic mode fires with empty FIFO, no DMA when disabled
    writeMode(1);
    ticks(3);
    check(irqOut, 1, "R5 periodic fire");
    check(dmaRxReq, 0, "R12 dma disabled");
    clearIrq();
    charRecv = 1; charTick = 1; step(); ticks(2);
    check(irqOut, 1, "R5 periodic recurs");
    clearIrq();

    // R11 configuration write restarts count
    ticks(2); writeLimit(16'd3); ticks(2);
    check(irqOut, 0, "R11 restart on write");
    ticks(1);
    check(irqOut, 1, "R11 fires after restart");
    clearIrq();

    // R6 expiry together with identification read keeps it set
    ticks(2); charTick = 1; rdIdent = 1; step();
    check(irqOut, 1, "R6 expiry wins");
    clearIrq();

    // R10 zero threshold disables
    dmaEnable = 1;
    writeLimit(16'd0); ticks(10);
    check(irqOut, 0, "R10 zero limit irq");
    check(dmaRxReq, 0, "R10 zero limit dma");

    // R1 upper byte used: 0x0100 ticks
    writeLimit(16'h0100); ticks(255);
    check(irqOut, 0, "R1 upper byte early");
    ticks(1);
    check(irqOut, 1, "R1 upper byte fires");
    clearIrq();

    // Random phase against the reference model
    for (int i = 0; i < 4000; i++) begin
      fifoNonEmpty = ($urandom % 4) != 0;
      dmaEnable    = ($urandom % 2);
      charTick     = ($urandom % 3) == 0;
      charRecv     = ($urandom % 8) == 0;
      rdHolding    = ($urandom % 10) == 0;
      rdLineStat   = ($urandom % 6) == 0;
      rdModemStat  = ($urandom % 6) == 0;
      rdIdent      = ($urandom % 12) == 0;
      if (($urandom % 200) == 0) begin wrData = 8'($urandom % 6); wrLimitLo = 1; end
      else if (($urandom % 300) == 0) begin wrData = 8'($urandom); wrMode = 1; end
      else if (($urandom % 400) == 0) begin wrData = 8'h00; wrLimitHi = 1; end
      step();
      check(irqOut, mPend, "R3 R5 model irq");
      check(identCode, expIdent(mPend), "R9 model ident");
      check(dmaRxReq, mDma, "R12 model dma");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule